// File: doc/BRIEF.md
# Instruction Cache Maintenance Controller

This block carries out maintenance operations on a small direct-mapped primary instruction cache. A request consists of a three-bit operation code and a virtual address. The address is split into a tag, a line index and a doubleword offset. The controller owns the tag/valid array and the line data array together with its per-doubleword check bits. It also owns three registers that software can read and write: a tag-low register, a tag-high register and a check-bit register.

Some operations act on the indexed line directly: invalidate, read the tag into the registers, and write the tag from the registers. Other operations first compare the stored tag with the address: invalidate on a match, or write the line back to memory on a match. A fill reads a whole line from a doubleword-wide memory port that uses a request/acknowledge handshake. While the fill runs, a status input can make the check-bit register replace the computed parity of the addressed doubleword. Every operation ends with a one-cycle `done` pulse. An operation is taken only while `busy` is low.

Top module: `icache_maint_ctrl`

## Requirements
- R1: After reset, every line is invalid and its stored tag and check bits are zero. The three registers read zero. `done`, `illegal_op`, `busy` and `mem_req` are low.
- R2: Code 0 clears the valid bit of the indexed line whatever the address tag is, and leaves the stored tag unchanged.
- R3: Code 1 loads the tag-low register with the valid bit at bit 31 and tag bits 23..0 at bits 23..0, with zeros elsewhere. It loads the tag-high register with the tag bits above 23, zero-extended. It loads the check-bit register with the stored check bits of the doubleword selected by the address offset. No parity error is ever reported.
- R4: Code 2 writes the indexed line's tag from tag-high bits 3..0 (upper tag) and tag-low bits 23..0 (lower tag). The valid bit is taken from tag-low bit 31.
- R5: Code 4 clears the valid bit of the indexed line only on a hit. On a miss the line is left unchanged.
- R6: A hit requires the indexed line to be valid and its stored tag to equal address bits 35..8. An invalid line with a matching tag is a miss.
- R7: Code 5 reads the four doublewords of the addressed line from memory at ascending addresses, starting at the line base. Each one is stored in the line as it arrives. When the last one arrives, the line becomes valid with the address tag.
- R8: The check bits stored by a fill are even parity per byte: bit i is the XOR of byte i. When `status_ce` is high at the start of the fill, the doubleword at the address offset takes the check-bit register value instead.
- R9: Code 6 on a hit writes all four stored doublewords of the line to memory at ascending addresses, with `mem_we` high, and leaves the line state unchanged. On a miss it makes no memory request.
- R10: For operations that make no memory transfer, `done` is high in the cycle after the operation is accepted. For memory operations, `done` is high in the cycle after the last acknowledge. `busy` is high exactly while transfers are pending.
- R11: Codes 3 and 7 change no state. They raise `illegal_op` together with `done` for one cycle.
- R12: A software write with select 0, 1 or 2 loads the tag-low, tag-high or check-bit register (check-bit register takes data bits 7..0). The new value is visible the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation request, taken when `busy` is low |
| op_code | input | 3 | Operation code |
| op_addr | input | 36 | Virtual address of the operation |
| status_ce | input | 1 | Selects register check bits for the addressed doubleword during a fill |
| sw_wr | input | 1 | Software register write strobe |
| sw_sel | input | 2 | Register select: 0 tag-low, 1 tag-high, 2 check bits |
| sw_wdata | input | 32 | Software write data |
| taglo | output | 32 | Tag-low register |
| taghi | output | 32 | Tag-high register |
| ecc | output | 8 | Check-bit register |
| busy | output | 1 | Memory transfers in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal_op | output | 1 | Unsupported code pulse |
| mem_req | output | 1 | Memory transfer request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 36 | Byte address of the doubleword |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Transfer acknowledge |

## Verification
The bench walks every line through tag store and load, fill and write-back. It alternates the parity-source select, and it moves the substituted doubleword to each offset. A design that applied the register check bits to the whole line, or to the wrong offset, would load mismatching check bits in the tag-read that follows. Hit-addressed operations are tried with a wrong tag and with a correct tag on an invalid line. A design that compared only tags would invalidate or write back lines it must leave alone. The bench also checks that the index invalidate keeps the stored tag, that unsupported codes leave the registers and the line untouched, and that `done` comes exactly one cycle after the last acknowledge rather than one cycle early or late.

// File: rtl/icm_pkg.sv
// Package: shared constants for the instruction cache maintenance controller.
// Assumes a 3-bit operation code and 32-bit software registers.
package icm_pkg;
    localparam logic [2:0] OPC_IDX_INV   = 3'd0;
    localparam logic [2:0] OPC_IDX_LDTAG = 3'd1;
    localparam logic [2:0] OPC_IDX_STTAG = 3'd2;
    localparam logic [2:0] OPC_HIT_INV   = 3'd4;
    localparam logic [2:0] OPC_FILL      = 3'd5;
    localparam logic [2:0] OPC_HIT_WB    = 3'd6;

    localparam logic [1:0] SEL_TAGLO = 2'd0;
    localparam logic [1:0] SEL_TAGHI = 2'd1;
    localparam logic [1:0] SEL_ECC   = 2'd2;

    localparam int REG_W          = 32;
    localparam int TAGLO_VALID    = 31;
    localparam int TAGLO_TAG_BITS = 24;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_WB   = 2'd2
    } icm_state_e;
endpackage

// File: rtl/icm_parity.sv
// Module: per-byte even-parity generator.
// Output bit i is the XOR of byte i of the input; DATA_W is a multiple of 8.
module icm_parity #(
    parameter int DATA_W = 64,
    localparam int PAR_W = DATA_W / 8
) (
    input  logic [DATA_W-1:0] data,
    output logic [PAR_W-1:0]  par
);
    for (genvar b = 0; b < PAR_W; b++) begin : g_byte
        // Reduce one byte to its parity bit.
        assign par[b] = ^data[8*b +: 8];
    end
endmodule

// File: rtl/icm_tag_store.sv
// Module: tag and valid storage for a direct-mapped cache, one entry per line.
// Read is combinational; one synchronous write port; reset clears all entries.
module icm_tag_store #(
    parameter int IDX_W = 3,
    parameter int TAG_W = 28,
    localparam int LINES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    for (genvar l = 0; l < LINES; l++) begin : g_line
        // Update one line's entry when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[l] <= 1'b0;
                tag_q[l]   <= '0;
            end else if (wr_en && wr_idx == IDX_W'(l)) begin
                valid_q[l] <= wr_valid;
                tag_q[l]   <= wr_tag;
            end
        end
    end

    // Present the indexed entry.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
    end
endmodule

// File: rtl/icm_line_store.sv
// Module: line data and check-bit storage, addressed by line index and doubleword.
// Read is combinational; one synchronous write port; reset clears contents.
module icm_line_store #(
    parameter int IDX_W  = 3,
    parameter int DW_W   = 2,
    parameter int DATA_W = 64,
    localparam int PAR_W   = DATA_W / 8,
    localparam int ENTRIES = 1 << (IDX_W + DW_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DW_W-1:0]   rd_dw,
    output logic [DATA_W-1:0] rd_data,
    output logic [PAR_W-1:0]  rd_par,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DW_W-1:0]   wr_dw,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PAR_W-1:0]  wr_par
);
    logic [DATA_W-1:0] data_q [ENTRIES];
    logic [PAR_W-1:0]  par_q  [ENTRIES];

    logic [IDX_W+DW_W-1:0] rd_ent;
    logic [IDX_W+DW_W-1:0] wr_ent;

    assign rd_ent = {rd_idx, rd_dw};
    assign wr_ent = {wr_idx, wr_dw};

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        // Store one doubleword and its check bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[e] <= '0;
                par_q[e]  <= '0;
            end else if (wr_en && wr_ent == (IDX_W+DW_W)'(e)) begin
                data_q[e] <= wr_data;
                par_q[e]  <= wr_par;
            end
        end
    end

    // Present the addressed doubleword.
    always_comb begin
        rd_data = data_q[rd_ent];
        rd_par  = par_q[rd_ent];
    end
endmodule

// File: rtl/icm_ctrl.sv
// Module: sequencer for cache maintenance operations.
// Decodes the code, runs index and hit operations in one cycle and fill or
// write-back over the memory port; owns the software registers.
// Assumes TAG_W exceeds the 24 tag bits kept in the tag-low register.
module icm_ctrl
    import icm_pkg::*;
#(
    parameter int ADDR_W = 36,
    parameter int IDX_W  = 3,
    parameter int DW_W   = 2,
    parameter int DATA_W = 64,
    localparam int PAR_W   = DATA_W / 8,
    localparam int OFF_W   = DW_W + 3,
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
    localparam int BASE_W  = ADDR_W - OFF_W,
    localparam int TAGHI_W = TAG_W - TAGLO_TAG_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              status_ce,
    input  logic              sw_wr,
    input  logic [1:0]        sw_sel,
    input  logic [REG_W-1:0]  sw_wdata,
    output logic [REG_W-1:0]  taglo,
    output logic [REG_W-1:0]  taghi,
    output logic [PAR_W-1:0]  ecc,
    output logic              busy,
    output logic              done,
    output logic              illegal_op,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic [PAR_W-1:0]  rdata_par,
    output logic [IDX_W-1:0]  tag_rd_idx,
    input  logic              tag_rd_valid,
    input  logic [TAG_W-1:0]  tag_rd_tag,
    output logic              tag_wr_en,
    output logic [IDX_W-1:0]  tag_wr_idx,
    output logic              tag_wr_valid,
    output logic [TAG_W-1:0]  tag_wr_tag,
    output logic [IDX_W-1:0]  ln_rd_idx,
    output logic [DW_W-1:0]   ln_rd_dw,
    input  logic [DATA_W-1:0] ln_rd_data,
    input  logic [PAR_W-1:0]  ln_rd_par,
    output logic              ln_wr_en,
    output logic [IDX_W-1:0]  ln_wr_idx,
    output logic [DW_W-1:0]   ln_wr_dw,
    output logic [DATA_W-1:0] ln_wr_data,
    output logic [PAR_W-1:0]  ln_wr_par
);
    localparam logic [DW_W-1:0] DW_LAST = {DW_W{1'b1}};

    icm_state_e        state_q;
    logic [DW_W-1:0]   cnt_q;
    logic [BASE_W-1:0] base_q;
    logic [DW_W-1:0]   sel_dw_q;
    logic              ce_q;
    logic              done_q;
    logic              illegal_q;
    logic [REG_W-1:0]  taglo_q;
    logic [REG_W-1:0]  taghi_q;
    logic [PAR_W-1:0]  ecc_q;

    logic [TAG_W-1:0]  op_tag;
    logic [IDX_W-1:0]  op_idx;
    logic [DW_W-1:0]   op_dw;
    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic              accept;
    logic              hit;
    logic              last_beat;
    logic [REG_W-1:0]  taglo_img;
    logic [REG_W-1:0]  taghi_img;

    assign op_tag    = op_addr[ADDR_W-1 -: TAG_W];
    assign op_idx    = op_addr[OFF_W +: IDX_W];
    assign op_dw     = op_addr[3 +: DW_W];
    assign cur_idx   = base_q[IDX_W-1:0];
    assign cur_tag   = base_q[BASE_W-1 -: TAG_W];
    assign accept    = op_valid && (state_q == ST_IDLE);
    assign hit       = tag_rd_valid && (tag_rd_tag == op_tag);
    assign last_beat = mem_ack && (cnt_q == DW_LAST);

    // Build the register images of the indexed tag for a tag read.
    always_comb begin
        taglo_img = '0;
        taglo_img[TAGLO_VALID] = tag_rd_valid;
        taglo_img[TAGLO_TAG_BITS-1:0] = tag_rd_tag[TAGLO_TAG_BITS-1:0];
        taghi_img = '0;
        taghi_img[TAGHI_W-1:0] = tag_rd_tag[TAG_W-1 -: TAGHI_W];
    end

    // Select the tag array write for the accepted operation or a finished fill.
    always_comb begin
        tag_rd_idx   = op_idx;
        tag_wr_en    = 1'b0;
        tag_wr_idx   = op_idx;
        tag_wr_valid = 1'b0;
        tag_wr_tag   = tag_rd_tag;
        if (accept) begin
            case (op_code)
                OPC_IDX_INV: tag_wr_en = 1'b1;
                OPC_HIT_INV: tag_wr_en = hit;
                OPC_IDX_STTAG: begin
                    tag_wr_en    = 1'b1;
                    tag_wr_valid = taglo_q[TAGLO_VALID];
                    tag_wr_tag   = {taghi_q[TAGHI_W-1:0], taglo_q[TAGLO_TAG_BITS-1:0]};
                end
                default: tag_wr_en = 1'b0;
            endcase
        end else if (state_q == ST_FILL && last_beat) begin
            tag_wr_en    = 1'b1;
            tag_wr_idx   = cur_idx;
            tag_wr_valid = 1'b1;
            tag_wr_tag   = cur_tag;
        end
    end

    // Drive the line array ports: fill writes, write-back and tag-read reads.
    always_comb begin
        ln_wr_en   = (state_q == ST_FILL) && mem_ack;
        ln_wr_idx  = cur_idx;
        ln_wr_dw   = cnt_q;
        ln_wr_data = mem_rdata;
        ln_wr_par  = (ce_q && cnt_q == sel_dw_q) ? ecc_q : rdata_par;
        if (state_q == ST_WB) begin
            ln_rd_idx = cur_idx;
            ln_rd_dw  = cnt_q;
        end else begin
            ln_rd_idx = op_idx;
            ln_rd_dw  = op_dw;
        end
    end

    // Drive the memory port from the transfer state.
    always_comb begin
        mem_req   = (state_q != ST_IDLE);
        mem_we    = (state_q == ST_WB);
        mem_addr  = {base_q, cnt_q, 3'b000};
        mem_wdata = ln_rd_data;
    end

    // Sequence operations and hold the software registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            base_q    <= '0;
            sel_dw_q  <= '0;
            ce_q      <= 1'b0;
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            taglo_q   <= '0;
            taghi_q   <= '0;
            ecc_q     <= '0;
        end else begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            if (sw_wr) begin
                case (sw_sel)
                    SEL_TAGLO: taglo_q <= sw_wdata;
                    SEL_TAGHI: taghi_q <= sw_wdata;
                    SEL_ECC:   ecc_q   <= sw_wdata[PAR_W-1:0];
                    default:   ;
                endcase
            end
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        case (op_code)
                            OPC_IDX_INV, OPC_IDX_STTAG, OPC_HIT_INV: done_q <= 1'b1;
                            OPC_IDX_LDTAG: begin
                                taglo_q <= taglo_img;
                                taghi_q <= taghi_img;
                                ecc_q   <= ln_rd_par;
                                done_q  <= 1'b1;
                            end
                            OPC_FILL: begin
                                base_q   <= op_addr[ADDR_W-1:OFF_W];
                                cnt_q    <= '0;
                                sel_dw_q <= op_dw;
                                ce_q     <= status_ce;
                                state_q  <= ST_FILL;
                            end
                            OPC_HIT_WB: begin
                                if (hit) begin
                                    base_q  <= op_addr[ADDR_W-1:OFF_W];
                                    cnt_q   <= '0;
                                    state_q <= ST_WB;
                                end else begin
                                    done_q <= 1'b1;
                                end
                            end
                            default: begin
                                done_q    <= 1'b1;
                                illegal_q <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_FILL, ST_WB: begin
                    if (last_beat) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else if (mem_ack) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign taglo      = taglo_q;
    assign taghi      = taghi_q;
    assign ecc        = ecc_q;
    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign illegal_op = illegal_q;
endmodule

// File: rtl/icache_maint_ctrl.sv
// Module: top of the instruction cache maintenance controller.
// Connects sequencer, tag array, line array and the parity generator used
// on fill data. Memory is a doubleword request/acknowledge port.
module icache_maint_ctrl
    import icm_pkg::*;
#(
    parameter int ADDR_W = 36,
    parameter int IDX_W  = 3,
    parameter int DW_W   = 2,
    parameter int DATA_W = 64,
    localparam int PAR_W = DATA_W / 8,
    localparam int OFF_W = DW_W + 3,
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              status_ce,
    input  logic              sw_wr,
    input  logic [1:0]        sw_sel,
    input  logic [REG_W-1:0]  sw_wdata,
    output logic [REG_W-1:0]  taglo,
    output logic [REG_W-1:0]  taghi,
    output logic [PAR_W-1:0]  ecc,
    output logic              busy,
    output logic              done,
    output logic              illegal_op,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    logic [PAR_W-1:0]  rdata_par;
    logic [IDX_W-1:0]  tag_rd_idx;
    logic              tag_rd_valid;
    logic [TAG_W-1:0]  tag_rd_tag;
    logic              tag_wr_en;
    logic [IDX_W-1:0]  tag_wr_idx;
    logic              tag_wr_valid;
    logic [TAG_W-1:0]  tag_wr_tag;
    logic [IDX_W-1:0]  ln_rd_idx;
    logic [DW_W-1:0]   ln_rd_dw;
    logic [DATA_W-1:0] ln_rd_data;
    logic [PAR_W-1:0]  ln_rd_par;
    logic              ln_wr_en;
    logic [IDX_W-1:0]  ln_wr_idx;
    logic [DW_W-1:0]   ln_wr_dw;
    logic [DATA_W-1:0] ln_wr_data;
    logic [PAR_W-1:0]  ln_wr_par;

    icm_parity #(.DATA_W(DATA_W)) u_par (
        .data (mem_rdata),
        .par  (rdata_par)
    );

    icm_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (tag_rd_idx),
        .rd_valid (tag_rd_valid),
        .rd_tag   (tag_rd_tag),
        .wr_en    (tag_wr_en),
        .wr_idx   (tag_wr_idx),
        .wr_valid (tag_wr_valid),
        .wr_tag   (tag_wr_tag)
    );

    icm_line_store #(.IDX_W(IDX_W), .DW_W(DW_W), .DATA_W(DATA_W)) u_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (ln_rd_idx),
        .rd_dw   (ln_rd_dw),
        .rd_data (ln_rd_data),
        .rd_par  (ln_rd_par),
        .wr_en   (ln_wr_en),
        .wr_idx  (ln_wr_idx),
        .wr_dw   (ln_wr_dw),
        .wr_data (ln_wr_data),
        .wr_par  (ln_wr_par)
    );

    icm_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DW_W(DW_W), .DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid     (op_valid),
        .op_code      (op_code),
        .op_addr      (op_addr),
        .status_ce    (status_ce),
        .sw_wr        (sw_wr),
        .sw_sel       (sw_sel),
        .sw_wdata     (sw_wdata),
        .taglo        (taglo),
        .taghi        (taghi),
        .ecc          (ecc),
        .busy         (busy),
        .done         (done),
        .illegal_op   (illegal_op),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .mem_ack      (mem_ack),
        .rdata_par    (rdata_par),
        .tag_rd_idx   (tag_rd_idx),
        .tag_rd_valid (tag_rd_valid),
        .tag_rd_tag   (tag_rd_tag),
        .tag_wr_en    (tag_wr_en),
        .tag_wr_idx   (tag_wr_idx),
        .tag_wr_valid (tag_wr_valid),
        .tag_wr_tag   (tag_wr_tag),
        .ln_rd_idx    (ln_rd_idx),
        .ln_rd_dw     (ln_rd_dw),
        .ln_rd_data   (ln_rd_data),
        .ln_rd_par    (ln_rd_par),
        .ln_wr_en     (ln_wr_en),
        .ln_wr_idx    (ln_wr_idx),
        .ln_wr_dw     (ln_wr_dw),
        .ln_wr_data   (ln_wr_data),
        .ln_wr_par    (ln_wr_par)
    );
endmodule

// File: rtl/icm_checks.sv
// Module: protocol and completion checks for the maintenance controller,
// bound to the top module. Assumes a synchronous active-low reset.
module icm_checks #(
    parameter int ADDR_W = 36,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              illegal_op,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack
);
    // An unanswered request keeps its address and direction.
    assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // Within one operation, the address advances by one doubleword per acknowledge.
    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req && mem_ack)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(8)));

    // Write-back data does not move while the write waits.
    assert_wdata_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata));

    // Nothing is requested while idle.
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // Completion is reported only once the controller is idle again.
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // An unsupported code completes in the same cycle it is flagged.
    assert_illegal_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> done);
endmodule

bind icache_maint_ctrl icm_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .illegal_op (illegal_op),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack)
);

// File: tb/test_icache_maint_ctrl.sv
// Bench: sweeps every line through tag store/load, fill, write-back and the
// hit and illegal corner cases, with expected values computed arithmetically.
module test_icache_maint_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [35:0] op_addr = '0;
    logic        status_ce = 1'b0;
    logic        sw_wr = 1'b0;
    logic [1:0]  sw_sel = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] taglo, taghi;
    logic [7:0]  ecc;
    logic        busy, done, illegal_op;
    logic        mem_req, mem_we;
    logic [35:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int total = 0;
    int bad = 0;

    logic [35:0] log_addr [8];
    logic [63:0] log_data [8];
    logic        log_we [8];
    int          log_n = 0;

    icache_maint_ctrl i_icache_maint_ctrl (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_addr(op_addr), .status_ce(status_ce), .sw_wr(sw_wr), .sw_sel(sw_sel),
        .sw_wdata(sw_wdata), .taglo(taglo), .taghi(taghi), .ecc(ecc),
        .busy(busy), .done(done), .illegal_op(illegal_op), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] pat(input logic [35:0] a);
        return {a[35:4], 4'hF, ~a[27:0]};
    endfunction

    function automatic logic [7:0] par(input logic [63:0] d);
        logic [7:0] p;
        for (int i = 0; i < 8; i++) p[i] = ^d[8*i +: 8];
        return p;
    endfunction

    function automatic logic [35:0] mk(input logic [27:0] t, input int idx, input int dw);
        return {t, 3'(idx), 2'(dw), 3'b000};
    endfunction

    function automatic logic [27:0] ftag(input int idx);
        return 28'h5C0_0000 + 28'(idx) * 28'h013_5791;
    endfunction

    // Memory model: one acknowledge per request, every other cycle.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            if (log_n < 8) begin
                log_addr[log_n] = mem_addr;
                log_data[log_n] = mem_wdata;
                log_we[log_n]   = mem_we;
            end
            log_n = log_n + 1;
            mem_rdata <= pat(mem_addr);
            mem_ack   <= 1'b1;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic sw_write(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        sw_wr = 1'b1; sw_sel = sel; sw_wdata = val;
        @(negedge clk);
        sw_wr = 1'b0;
        #1;
    endtask

    // Issue one operation; return cycles waited after the first sample,
    // acknowledge seen at the sample before done, and illegal_op at done.
    task automatic do_op(input logic [2:0] code, input logic [35:0] addr,
                         output int n, output bit prev_ack, output bit ill);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_addr = addr; log_n = 0;
        @(negedge clk);
        op_valid = 1'b0;
        #1;
        n = 0; prev_ack = 1'b0;
        while (!done && n < 64) begin
            prev_ack = mem_ack;
            @(negedge clk);
            #1;
            n++;
        end
        ill = illegal_op;
    endtask

    task automatic load_tag(input logic [35:0] addr);
        int n; bit pa; bit ill;
        do_op(3'd1, addr, n, pa, ill);
        check(n == 0 && !ill, "R10 tag read timing", 64'(n), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R10 watchdog act=timeout exp=completion");
        finish_run();
    end

    initial begin
        int n; bit pa; bit ill;
        logic [31:0] keep_lo;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(!done && !illegal_op && !busy && !mem_req, "R1 outputs idle",
              {busy, done, illegal_op, mem_req}, 64'd0);
        check(taglo == 0 && taghi == 0 && ecc == 0, "R1 registers zero", {taglo, taghi}, 64'd0);
        load_tag(mk(28'h0, 5, 1));
        check(taglo == 0 && taghi == 0 && ecc == 0, "R1 line invalid after reset", {taglo, ecc}, 64'd0);

        // R12: software register writes
        sw_write(2'd0, 32'hDEAD_BEEF);
        check(taglo == 32'hDEAD_BEEF, "R12 tag-low write", taglo, 64'hDEAD_BEEF);
        sw_write(2'd1, 32'h1234_5678);
        check(taghi == 32'h1234_5678, "R12 tag-high write", taghi, 64'h1234_5678);
        sw_write(2'd2, 32'h0000_01A5);
        check(ecc == 8'hA5, "R12 check-bit write", ecc, 64'hA5);

        // R4 / R3: store then read back a tag on every line
        for (int i = 0; i < 8; i++) begin
            logic [27:0] t;
            t = 28'hA00_0000 ^ (28'(i) * 28'h111_1111);
            sw_write(2'd0, {1'b1, 7'b0, t[23:0]});
            sw_write(2'd1, {28'b0, t[27:24]});
            do_op(3'd2, mk(28'h0, i, 0), n, pa, ill);
            check(n == 0 && !ill, "R10 tag store timing", 64'(n), 64'd0);
            sw_write(2'd0, 32'h0);
            sw_write(2'd1, 32'h0);
            load_tag(mk(28'h0, i, 0));
            check(taglo == {1'b1, 7'b0, t[23:0]}, "R4 R3 tag-low readback", taglo, {1'b1, 7'b0, t[23:0]});
            check(taghi == {28'b0, t[27:24]}, "R4 R3 tag-high readback", taghi, {28'b0, t[27:24]});
        end

        // R7 / R8: fill every line, alternating the check-bit source and offset
        for (int i = 0; i < 8; i++) begin
            logic [7:0] ev;
            bit ce;
            ce = i[0];
            ev = 8'hC0 ^ 8'(i * 7);
            sw_write(2'd2, {24'b0, ev});
            status_ce = ce;
            do_op(3'd5, mk(ftag(i), i, i % 4), n, pa, ill);
            status_ce = 1'b0;
            check(log_n == 4, "R7 fill transfer count", 64'(log_n), 64'd4);
            check(n > 0 && pa && !ill, "R10 done one cycle after last acknowledge", {pa, ill}, 64'd2);
            for (int k = 0; k < 4; k++)
                check(log_addr[k] == mk(ftag(i), i, k) && !log_we[k], "R7 fill address order",
                      log_addr[k], mk(ftag(i), i, k));
            for (int k = 0; k < 4; k++) begin
                logic [7:0] exp_p;
                exp_p = (ce && k == i % 4) ? ev : par(pat(mk(ftag(i), i, k)));
                load_tag(mk(ftag(i), i, k));
                check(ecc == exp_p, "R8 stored check bits", ecc, exp_p);
                check(taglo == {1'b1, 7'b0, ftag(i)[23:0]} && taghi == {28'b0, ftag(i)[27:24]},
                      "R7 line valid with fill tag", taglo, {1'b1, 7'b0, ftag(i)[23:0]});
            end
        end

        // R9 / R6: write back on hit, nothing on miss
        for (int i = 0; i < 8; i++) begin
            do_op(3'd6, mk(ftag(i), i, 2), n, pa, ill);
            check(log_n == 4 && pa, "R9 write-back count and timing", 64'(log_n), 64'd4);
            for (int k = 0; k < 4; k++) begin
                check(log_addr[k] == mk(ftag(i), i, k) && log_we[k], "R9 write-back address",
                      log_addr[k], mk(ftag(i), i, k));
                check(log_data[k] == pat(mk(ftag(i), i, k)), "R9 write-back data",
                      log_data[k], pat(mk(ftag(i), i, k)));
            end
            do_op(3'd6, mk(ftag(i) ^ 28'h1, i, 0), n, pa, ill);
            check(log_n == 0 && n == 0, "R6 R9 miss makes no request", 64'(log_n), 64'd0);
        end
        load_tag(mk(ftag(3), 3, 0));
        check(taglo[31] == 1'b1, "R9 line stays valid after write-back", taglo, 64'h1);

        // R5 / R6: hit invalidate on miss then on hit
        do_op(3'd4, mk(ftag(0) ^ 28'h100, 0, 0), n, pa, ill);
        check(n == 0 && !ill, "R10 hit invalidate timing", 64'(n), 64'd0);
        load_tag(mk(ftag(0), 0, 0));
        check(taglo[31] == 1'b1, "R5 miss leaves line valid", taglo, 64'h1);
        do_op(3'd4, mk(ftag(0), 0, 0), n, pa, ill);
        load_tag(mk(ftag(0), 0, 0));
        check(taglo == {8'b0, ftag(0)[23:0]}, "R5 hit clears valid", taglo, {8'b0, ftag(0)[23:0]});
        do_op(3'd6, mk(ftag(0), 0, 0), n, pa, ill);
        check(log_n == 0, "R6 invalid line with matching tag is a miss", 64'(log_n), 64'd0);

        // R2: index invalidate ignores the address tag
        do_op(3'd0, mk(28'h0ABCDEF, 1, 3), n, pa, ill);
        check(n == 0 && !ill, "R10 index invalidate timing", 64'(n), 64'd0);
        load_tag(mk(28'h0, 1, 0));
        check(taglo == {8'b0, ftag(1)[23:0]} && taghi == {28'b0, ftag(1)[27:24]},
              "R2 valid cleared, tag kept", taglo, {8'b0, ftag(1)[23:0]});

        // R11: unsupported codes change nothing
        load_tag(mk(ftag(2), 2, 1));
        keep_lo = taglo;
        do_op(3'd3, mk(ftag(2), 2, 1), n, pa, ill);
        check(ill && n == 0, "R11 code 3 flagged with done", {ill, 32'(n)}, 64'h1_0000_0000);
        check(taglo == keep_lo && log_n == 0, "R11 code 3 leaves registers", taglo, keep_lo);
        do_op(3'd7, mk(ftag(2), 2, 1), n, pa, ill);
        check(ill && n == 0, "R11 code 7 flagged with done", {ill, 32'(n)}, 64'h1_0000_0000);
        @(negedge clk); #1;
        check(!illegal_op, "R11 flag lasts one cycle", illegal_op, 64'd0);
        load_tag(mk(ftag(2), 2, 1));
        check(taglo == keep_lo, "R11 line unchanged", taglo, keep_lo);

        finish_run();
    end
endmodule